// File: doc/BRIEF.md
# Priority-Mapped Vectored Interrupt Controller

This block gathers a wide set of level-sensitive interrupt requests and presents the most urgent one to a processor core. Every request line owns a small configuration word holding an enable bit and a 4-bit priority level. Any source may sit at any level. A separate routing word decides, level by level, whether a winning request at that level is signalled on the fast interrupt line or on the normal one.

Software services an interrupt by reading an acknowledge location. The read returns the number of the winning source, or a reserved spurious code when nothing qualifies. As a side effect it raises the priority threshold, so that the acknowledged level and every level below it are held off. A one-deep hardware slot keeps the threshold that was in force before the acknowledge, and a write to the end-of-interrupt location puts it back. Deeper nesting is handled by software, which reads and rewrites the threshold through its own register.

Host access uses a single-cycle register port. Reads are combinational in the cycle the select is high, and writes and read side effects take effect at the next rising clock edge.

Top module: `vic_prio`

## Requirements
- R1: After synchronous reset, both interrupt outputs are low, every source is disabled at level 0, all levels route to the normal output, the threshold is 0 and the save slot is empty.
- R2: Word addresses 0 to 63 hold the source configuration. A write stores bit 4 as the enable and bits 3:0 as the level, and a read returns them at the same positions with the other bits zero.
- R3: A request qualifies only when its line is high, its source is enabled and its level is greater than or equal to the current threshold. An output rises one clock after the cycle in which a qualifying request exists and stays low otherwise.
- R4: Address 64 holds the 16-bit routing word. When bit L is 1, a winner at level L drives the fast output, and when it is 0 the winner drives the normal output. The two outputs are never high together.
- R5: Among qualifying requests the highest level wins. Level 15 is the most urgent, and among sources at the same level the lowest source number wins.
- R6: A read of address 66 returns the winning source number (0 to 63) in the low bits. When nothing qualifies it returns 64 and leaves the threshold and the save slot unchanged.
- R7: An acknowledge read with a winner at level L copies the old threshold into the save slot, marks the slot valid and sets the threshold to L+1. Threshold 16 blocks every level.
- R8: A write to address 67 while the slot is valid restores the saved threshold and empties the slot. With the slot empty, the write changes nothing.
- R9: Address 65 reads back the threshold in bits 4:0, the saved threshold in bits 12:8 and the slot-valid flag in bit 16. A write there sets the threshold from bits 4:0 and leaves the slot alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 64 | Level-sensitive interrupt request lines |
| bus_sel_i | input | 1 | Register access strobe, one access per cycle |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 7 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while the strobe is high |
| irq_fast_o | output | 1 | Fast interrupt request to the core |
| irq_norm_o | output | 1 | Normal interrupt request to the core |

## Verification
The assertions assume that the host issues at most one access per cycle and that one select cycle on the acknowledge address means exactly one acknowledge. They also assume the request lines are stable around the rising edge. The stimulus drives every input at the falling edge and holds the select for a single cycle per access. Request patterns, configuration writes, threshold writes, acknowledges and end-of-interrupt writes are mixed at random on top of the directed sequences. Threshold values stay within 0 to 16, so every nesting depth and the all-blocked state are reached.

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int NSRC = 64,
  parameter int LVLW = 4,
  parameter int DW   = 32,
  parameter int AW   = 7
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [NSRC-1:0] req_i,
  input  logic            bus_sel_i,
  input  logic            bus_wr_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            irq_fast_o,
  output logic            irq_norm_o
);

  localparam int NLVL = 1 << LVLW;
  localparam int VW   = $clog2(NSRC + 1);
  localparam int SW   = $clog2(NSRC);
  localparam int TW   = LVLW + 1;
  localparam logic [AW-1:0] A_ROUTE = AW'(NSRC);
  localparam logic [AW-1:0] A_MASK  = AW'(NSRC + 1);
  localparam logic [AW-1:0] A_ACK   = AW'(NSRC + 2);
  localparam logic [AW-1:0] A_EOI   = AW'(NSRC + 3);

  logic            en_q  [NSRC];
  logic [LVLW-1:0] lvl_q [NSRC];
  logic [NLVL-1:0] route_q;
  logic [TW-1:0]   thr_q, sav_q;
  logic            sav_v_q;

  logic            win_hit;
  logic [VW-1:0]   win_idx;
  logic [LVLW-1:0] win_lvl;

  wire rd      = bus_sel_i && !bus_wr_i;
  wire wr      = bus_sel_i &&  bus_wr_i;
  wire cfg_sel = bus_addr_i < AW'(NSRC);
  wire ack_rd  = rd && (bus_addr_i == A_ACK);
  wire eoi_wr  = wr && (bus_addr_i == A_EOI);
  wire mask_wr = wr && (bus_addr_i == A_MASK);
  wire rte_wr  = wr && (bus_addr_i == A_ROUTE);
  wire [SW-1:0] sidx = bus_addr_i[SW-1:0];

  always_comb begin
    win_hit = 1'b0;
    win_idx = VW'(NSRC);
    win_lvl = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_i[i] && en_q[i] && ({1'b0, lvl_q[i]} >= thr_q) &&
          (!win_hit || lvl_q[i] > win_lvl)) begin
        win_hit = 1'b1;
        win_idx = VW'(i);
        win_lvl = lvl_q[i];
      end
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_cfg
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        en_q[g]  <= 1'b0;
        lvl_q[g] <= '0;
      end else if (wr && bus_addr_i == AW'(g)) begin
        en_q[g]  <= bus_wdata_i[LVLW];
        lvl_q[g] <= bus_wdata_i[LVLW-1:0];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      route_q <= '0;
      thr_q   <= '0;
      sav_q   <= '0;
      sav_v_q <= 1'b0;
    end else begin
      if (rte_wr) route_q <= bus_wdata_i[NLVL-1:0];
      if (ack_rd && win_hit) begin
        sav_q   <= thr_q;
        sav_v_q <= 1'b1;
        thr_q   <= {1'b0, win_lvl} + TW'(1);
      end else if (eoi_wr && sav_v_q) begin
        thr_q   <= sav_q;
        sav_v_q <= 1'b0;
      end else if (mask_wr) begin
        thr_q   <= bus_wdata_i[TW-1:0];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_fast_o <= 1'b0;
      irq_norm_o <= 1'b0;
    end else begin
      irq_fast_o <= win_hit &&  route_q[win_lvl];
      irq_norm_o <= win_hit && !route_q[win_lvl];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      if (cfg_sel) begin
        bus_rdata_o[LVLW]     = en_q[sidx];
        bus_rdata_o[LVLW-1:0] = lvl_q[sidx];
      end else if (bus_addr_i == A_ROUTE) begin
        bus_rdata_o[NLVL-1:0] = route_q;
      end else if (bus_addr_i == A_MASK) begin
        bus_rdata_o[TW-1:0]  = thr_q;
        bus_rdata_o[8 +: TW] = sav_q;
        bus_rdata_o[16]      = sav_v_q;
      end else if (bus_addr_i == A_ACK) begin
        bus_rdata_o[VW-1:0] = win_idx;
      end
    end
  end

  assert_one_output_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !(irq_fast_o && irq_norm_o));

  assert_out_has_cause_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_fast_o || irq_norm_o) |-> $past(win_hit));

  assert_ack_raises_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_rd && win_hit) |=> (sav_v_q && thr_q == ({1'b0, $past(win_lvl)} + TW'(1))));

  assert_spurious_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_rd && !win_hit) |=> ($stable(thr_q) && $stable(sav_v_q)));

  assert_eoi_restore_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (eoi_wr && sav_v_q) |=> (!sav_v_q && thr_q == $past(sav_q)));

  always_comb begin
    if (!rst_i && win_hit) assert_winner_range_R5: assert (win_idx < VW'(NSRC));
  end

endmodule

// File: tb/vic_prio_tb.sv
module vic_prio_tb;
  localparam int ACK = 66;
  localparam int EOI = 67;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] req = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq_f, irq_n;

  int compared = 0, mismatched = 0;
  int m_en[64], m_lvl[64], m_route[16];
  int m_thr, m_sav, m_sv;

  always #10 clk = ~clk;

  vic_prio u_dut (
    .clk_i(clk), .rst_i(rst), .req_i(req), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_fast_o(irq_f), .irq_norm_o(irq_n)
  );

  task automatic check(input string tag, input string what, input longint got, input longint exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) begin m_en[i] = 0; m_lvl[i] = 0; end
    for (int i = 0; i < 16; i++) m_route[i] = 0;
    m_thr = 0; m_sav = 0; m_sv = 0;
  endtask

  task automatic step(input logic s, input logic w, input int a, input logic [31:0] d,
                      input logic [63:0] rq, input string tag);
    int win, wl;
    longint ev;
    logic ef, en;
    @(negedge clk);
    sel = s; wr = w; addr = 7'(a); wdata = d; req = rq;
    #1;
    win = 64; wl = -1;
    for (int i = 0; i < 64; i++)
      if (rq[i] && m_en[i] != 0 && m_lvl[i] >= m_thr && m_lvl[i] > wl) begin
        win = i; wl = m_lvl[i];
      end
    if (s && !w) begin
      ev = 0;
      if (a < 64) ev = m_en[a] * 16 + m_lvl[a];
      else if (a == 64) begin
        for (int l = 0; l < 16; l++) if (m_route[l] != 0) ev = ev | (longint'(1) << l);
      end
      else if (a == 65) ev = m_thr + m_sav * 256 + m_sv * 65536;
      else if (a == ACK) ev = win;
      check(tag, "rdata", rdata, ev);
    end
    ef = (win < 64) && m_route[wl] != 0;
    en = (win < 64) && m_route[wl] == 0;
    if (s && !w && a == ACK && win < 64) begin
      m_sav = m_thr; m_sv = 1; m_thr = wl + 1;
    end else if (s && w && a == EOI && m_sv != 0) begin
      m_thr = m_sav; m_sv = 0;
    end else if (s && w) begin
      if (a < 64) begin m_en[a] = int'(d[4]); m_lvl[a] = int'(d[3:0]); end
      else if (a == 64) for (int l = 0; l < 16; l++) m_route[l] = int'(d[l]);
      else if (a == 65) m_thr = int'(d[4:0]);
    end
    @(posedge clk); #1;
    check(tag, "irq_fast", irq_f, ef);
    check(tag, "irq_norm", irq_n, en);
  endtask

  initial begin
    #4_000_000;
    compared++; mismatched++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] r;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1", "irq_fast", irq_f, 0);
    check("R1", "irq_norm", irq_n, 0);
    step(1, 0, 0, 0, '0, "R1");
    step(1, 0, 64, 0, '0, "R1");
    step(1, 0, 65, 0, '0, "R1");
    step(1, 0, ACK, 0, '1, "R1");

    step(1, 1, 5, 32'h13, '0, "R2");
    step(1, 0, 5, 0, '0, "R2");
    step(1, 1, 7, 32'hFFFF_FFE9, '0, "R2");
    step(1, 0, 7, 0, '0, "R2");
    step(1, 1, 7, 32'h09, '0, "R2");
    step(0, 0, 0, 0, 64'h80, "R3");
    step(0, 0, 0, 0, 64'h20, "R3");
    step(1, 1, 64, 32'h0008, 64'h20, "R4");
    step(0, 0, 0, 0, 64'h20, "R4");

    step(1, 1, 10, 32'h13, 64'h420, "R5");
    step(1, 0, ACK, 0, 64'h420, "R5");
    step(1, 1, 40, 32'h19, 64'h0000_0100_0000_0420, "R5");
    step(1, 0, ACK, 0, 64'h0000_0100_0000_0420, "R7");
    step(1, 0, 65, 0, 64'h0000_0100_0000_0420, "R9");
    step(0, 0, 0, 0, 64'h420, "R3");
    step(1, 1, 63, 32'h1F, 64'h8000_0100_0000_0420, "R7");
    step(1, 0, ACK, 0, 64'h8000_0100_0000_0420, "R7");
    step(1, 0, 65, 0, 64'h8000_0100_0000_0420, "R7");
    step(1, 0, ACK, 0, 64'h8000_0100_0000_0420, "R6");
    step(1, 1, EOI, 0, 64'h8000_0100_0000_0420, "R8");
    step(1, 0, 65, 0, 64'h8000_0100_0000_0420, "R8");
    step(1, 1, EOI, 0, 64'h8000_0100_0000_0420, "R8");
    step(1, 0, 65, 0, 64'h8000_0100_0000_0420, "R8");
    step(1, 1, 65, 32'h0000_0003, 64'h420, "R9");
    step(1, 0, 65, 0, 64'h420, "R9");
    step(1, 1, 65, 32'h0000_0010, 64'h420, "R7");
    step(1, 1, 65, 32'h0000_0000, 64'h420, "R9");

    for (int k = 0; k < 3000; k++) begin
      int op;
      r = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1: step(1, 1, int'($urandom_range(0, 63)), $urandom, r, "R2");
        2:    step(1, 1, 64, $urandom, r, "R4");
        3:    step(1, 1, 65, 32'($urandom_range(0, 16)), r, "R9");
        4, 5: step(1, 0, ACK, 0, r, "R6");
        6:    step(1, 1, EOI, 0, r, "R8");
        7:    step(1, 0, int'($urandom_range(0, 65)), 0, r, "R9");
        default: step(0, 0, 0, 0, r, "R5");
      endcase
    end
    summary();
  end
endmodule